// File: doc/BRIEF.md
# FPGA Configuration Handshake Sequencer

This block steps an FPGA configuration port through its start-up handshake. After a power-on or manual reset it runs a clear cycle. Once the clear cycle is done, it either goes straight into an automatic download or waits for the user to start one. It owns two open-drain status lines. The start/busy line tells the user when the port is ready and when a download is in progress. The init/error line lets an outside agent stretch the clear cycle, and the block uses it to report download errors and configuration-memory mismatches.

Each open-drain line appears as a drive-low enable output plus a pin-value input. The pin value passes through a two-flop synchronizer before the state machine sees it. A high-during-config output and a low-during-config output mark the configuration phases, and they follow user values at all other times. The current sequencer state is available on a port so that it can be observed. Bitstream parsing, memory writes and pin multiplexing are handled elsewhere. This block only receives their done, error and mismatch flags.

Top module: `cfg_handshake_seq`

## Requirements
- R1: Asynchronous reset (`rst_ni` low) forces state RESET. A one-cycle synchronous `manual_rst_i` moves the state to RESET on the next edge. The following edge always moves RESET to CLEAR. In RESET both drive-low enables are 1.
- R2: In CLEAR the init line is driven low until `clear_done_i` is seen, and released from the next edge. The block leaves CLEAR on the third rising edge after the init pin reads high. While something external holds the pin low, the block stays in CLEAR.
- R3: With `mode_i` (3 bits) not equal to 0, the block leaves CLEAR into WAIT_START and releases the start line there. This covers modes 2, 6 and 7 as well as every other non-zero value.
- R4: With `mode_i` equal to 0, the block leaves CLEAR directly into DOWNLOAD. The start line stays driven low without a gap from reset until the download ends.
- R5: A falling edge on the start pin while in WAIT_START or DONE moves the block to DELAY on the third rising edge after the pin falls. DELAY lasts exactly `START_DELAY` (3) cycles with the start line not driven by the block. The block then enters DOWNLOAD and drives the start line low.
- R6: In DOWNLOAD, `dl_done_i` without `bit_err_i` moves the block to DONE on the next edge, and the start line is released there.
- R7: In DOWNLOAD, `bit_err_i` moves the block to ERROR on the next edge, and takes priority over `dl_done_i`. ERROR drives both lines low and holds until a reset. `bit_err_i` has no effect in any other state.
- R8: In DONE, the init line is driven low in exactly the cycles where both `chk_active_i` and `chk_mismatch_i` are 1, with no clock delay. Otherwise the init line is released.
- R9: In RESET, CLEAR, DELAY, DOWNLOAD and ERROR, `hdc_o` is 1 and `ldc_o` is 0. In WAIT_START and DONE they follow `user_hdc_i` and `user_ldc_i`.
- R10: `state_o` encodes RESET=0, CLEAR=1, WAIT_START=2, DELAY=3, DOWNLOAD=4, DONE=5, ERROR=6. No other value ever appears.

Timing note for R2 and R5: the three edges come from the two synchronizer flops plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| manual_rst_i | input | 1 | Synchronous manual reset request |
| mode_i | input | 3 | Configuration mode; 0 selects automatic download |
| clear_done_i | input | 1 | Configuration clear cycle has finished |
| dl_done_i | input | 1 | Bitstream download has finished |
| bit_err_i | input | 1 | Bitstream error seen during download |
| chk_active_i | input | 1 | Integrity check of configuration memory is running |
| chk_mismatch_i | input | 1 | Integrity check found a mismatch |
| start_pin_i | input | 1 | Sampled level of the start/busy line |
| init_pin_i | input | 1 | Sampled level of the init/error line |
| user_hdc_i | input | 1 | User value for the high-during-config output |
| user_ldc_i | input | 1 | User value for the low-during-config output |
| start_drive_low_o | output | 1 | Drive-low enable for the start/busy line |
| init_drive_low_o | output | 1 | Drive-low enable for the init/error line |
| hdc_o | output | 1 | High-during-config indicator |
| ldc_o | output | 1 | Low-during-config indicator |
| state_o | output | 3 | Current sequencer state |

## Verification
A wrong state shows up on `state_o` on the same edge it happens. Within the same cycle it also shows up on the drive-low enables and on the phase indicators, so most faults appear at once. The subtler faults are off-by-one latencies. A wrong synchronizer depth or a wrong DELAY count shifts the point where the block takes over the start line by whole cycles, so the bench checks the exact edge on which each transition is expected. A missed release of the init line in CLEAR shows as the block never leaving CLEAR. A wrong mode decode shows within three cycles of the clear cycle ending.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RESET = 3'd0,
    ST_CLEAR = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DELAY = 3'd3,
    ST_LOAD  = 3'd4,
    ST_DONE  = 3'd5,
    ST_ERROR = 3'd6
  } cfg_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned       WIDTH   = 2,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
#(
  parameter int unsigned        MODE_W      = 3,
  parameter logic [MODE_W-1:0]  AUTO_MODE   = '0,
  parameter int unsigned        START_DELAY = 3,
  localparam int unsigned       CNT_W       = $clog2(START_DELAY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              manual_rst_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              clear_done_i,
  input  logic              dl_done_i,
  input  logic              bit_err_i,
  input  logic              start_s_i,
  input  logic              init_s_i,
  output cfg_state_e        state_o,
  output logic              start_dl_o,
  output logic              init_dl_o,
  output logic              cfg_phase_o
);
  cfg_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             clr_q;
  logic             start_prev_q;
  logic             start_fall;

  assign start_fall = start_prev_q & ~start_s_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET: state_d = ST_CLEAR;
      ST_CLEAR: if (clr_q && init_s_i)
                  state_d = (mode_i == AUTO_MODE) ? ST_LOAD : ST_WAIT;
      ST_WAIT:  if (start_fall) state_d = ST_DELAY;
      ST_DELAY: if (cnt_q == CNT_W'(START_DELAY - 1)) state_d = ST_LOAD;
      ST_LOAD:  if (bit_err_i)      state_d = ST_ERROR;
                else if (dl_done_i) state_d = ST_DONE;
      ST_DONE:  if (start_fall) state_d = ST_DELAY;
      ST_ERROR: state_d = ST_ERROR;
      default:  state_d = ST_RESET;
    endcase
    if (manual_rst_i) state_d = ST_RESET;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RESET;
      cnt_q        <= '0;
      clr_q        <= 1'b0;
      start_prev_q <= 1'b1;
    end else begin
      state_q      <= state_d;
      start_prev_q <= start_s_i;
      cnt_q        <= (state_q == ST_DELAY && state_d == ST_DELAY) ? cnt_q + 1'b1 : '0;
      if (state_q == ST_RESET)                      clr_q <= 1'b0;
      else if (state_q == ST_CLEAR && clear_done_i) clr_q <= 1'b1;
    end
  end

  assign state_o     = state_q;
  assign start_dl_o  = state_q inside {ST_RESET, ST_CLEAR, ST_LOAD, ST_ERROR};
  assign init_dl_o   = (state_q == ST_RESET) || (state_q == ST_ERROR) ||
                       (state_q == ST_CLEAR && !clr_q);
  assign cfg_phase_o = !(state_q inside {ST_WAIT, ST_DONE});
endmodule

// File: rtl/cfg_pin_ctrl.sv
module cfg_pin_ctrl
  import cfg_seq_pkg::*;
(
  input  cfg_state_e state_i,
  input  logic       start_dl_i,
  input  logic       init_dl_i,
  input  logic       cfg_phase_i,
  input  logic       chk_active_i,
  input  logic       chk_mismatch_i,
  input  logic       user_hdc_i,
  input  logic       user_ldc_i,
  output logic       start_drive_low_o,
  output logic       init_drive_low_o,
  output logic       hdc_o,
  output logic       ldc_o
);
  logic chk_flag;

  // mismatch reporting only once configured
  assign chk_flag          = (state_i == ST_DONE) && chk_active_i && chk_mismatch_i;
  assign start_drive_low_o = start_dl_i;
  assign init_drive_low_o  = init_dl_i | chk_flag;
  assign hdc_o             = cfg_phase_i ? 1'b1 : user_hdc_i;
  assign ldc_o             = cfg_phase_i ? 1'b0 : user_ldc_i;
endmodule

// File: rtl/cfg_handshake_seq.sv
module cfg_handshake_seq
  import cfg_seq_pkg::*;
#(
  parameter int unsigned        MODE_W      = 3,
  parameter logic [MODE_W-1:0]  AUTO_MODE   = '0,
  parameter int unsigned        START_DELAY = 3,
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               manual_rst_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               clear_done_i,
  input  logic               dl_done_i,
  input  logic               bit_err_i,
  input  logic               chk_active_i,
  input  logic               chk_mismatch_i,
  input  logic               start_pin_i,
  input  logic               init_pin_i,
  input  logic               user_hdc_i,
  input  logic               user_ldc_i,
  output logic               start_drive_low_o,
  output logic               init_drive_low_o,
  output logic               hdc_o,
  output logic               ldc_o,
  output logic [STATE_W-1:0] state_o
);
  logic [1:0] pins_s;
  cfg_state_e state;
  logic       start_dl, init_dl, cfg_phase;

  cfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({init_pin_i, start_pin_i}),
    .q_o    (pins_s)
  );

  cfg_seq_fsm #(.MODE_W(MODE_W), .AUTO_MODE(AUTO_MODE), .START_DELAY(START_DELAY)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .manual_rst_i (manual_rst_i),
    .mode_i       (mode_i),
    .clear_done_i (clear_done_i),
    .dl_done_i    (dl_done_i),
    .bit_err_i    (bit_err_i),
    .start_s_i    (pins_s[0]),
    .init_s_i     (pins_s[1]),
    .state_o      (state),
    .start_dl_o   (start_dl),
    .init_dl_o    (init_dl),
    .cfg_phase_o  (cfg_phase)
  );

  cfg_pin_ctrl u_pins (
    .state_i           (state),
    .start_dl_i        (start_dl),
    .init_dl_i         (init_dl),
    .cfg_phase_i       (cfg_phase),
    .chk_active_i      (chk_active_i),
    .chk_mismatch_i    (chk_mismatch_i),
    .user_hdc_i        (user_hdc_i),
    .user_ldc_i        (user_ldc_i),
    .start_drive_low_o (start_drive_low_o),
    .init_drive_low_o  (init_drive_low_o),
    .hdc_o             (hdc_o),
    .ldc_o             (ldc_o)
  );

  assign state_o = state;
endmodule

// File: rtl/cfg_handshake_seq_chk.sv
module cfg_handshake_seq_chk #(
  parameter int unsigned START_DELAY = 3,
  localparam int unsigned RUN_W      = $clog2(START_DELAY + 2)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       manual_rst_i,
  input logic       dl_done_i,
  input logic       bit_err_i,
  input logic       chk_active_i,
  input logic       chk_mismatch_i,
  input logic       start_drive_low_o,
  input logic       init_drive_low_o,
  input logic       hdc_o,
  input logic       ldc_o,
  input logic [2:0] state_o
);
  logic [RUN_W-1:0] dly_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               dly_run_q <= '0;
    else if (state_o == 3'd3)  dly_run_q <= dly_run_q + 1'b1;
    else                       dly_run_q <= '0;
  end

  a_r1_reset_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd0 |-> start_drive_low_o && init_drive_low_o);

  a_r1_manual_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    manual_rst_i |=> state_o == 3'd0);

  a_r3_wait_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd2 |-> !start_drive_low_o && !init_drive_low_o);

  a_r4_download_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd4 |-> start_drive_low_o);

  a_r5_delay_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd3 |-> dly_run_q < RUN_W'(START_DELAY));

  a_r6_done_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd4 && dl_done_i && !bit_err_i && !manual_rst_i |=> state_o == 3'd5);

  a_r7_error_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd6 && !manual_rst_i |=> state_o == 3'd6 && init_drive_low_o);

  a_r8_no_false_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd5 && !(chk_active_i && chk_mismatch_i) |-> !init_drive_low_o);

  a_r9_phase_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_o inside {3'd2, 3'd5}) |-> hdc_o && !ldc_o);

  a_r10_legal_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 3'd7);
endmodule

bind cfg_handshake_seq cfg_handshake_seq_chk #(.START_DELAY(START_DELAY)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .manual_rst_i      (manual_rst_i),
  .dl_done_i         (dl_done_i),
  .bit_err_i         (bit_err_i),
  .chk_active_i      (chk_active_i),
  .chk_mismatch_i    (chk_mismatch_i),
  .start_drive_low_o (start_drive_low_o),
  .init_drive_low_o  (init_drive_low_o),
  .hdc_o             (hdc_o),
  .ldc_o             (ldc_o),
  .state_o           (state_o)
);

// File: tb/cfg_handshake_seq_tb.sv
module cfg_handshake_seq_tb;
  localparam int S_RESET = 0, S_CLEAR = 1, S_WAIT = 2, S_DELAY = 3,
                 S_LOAD = 4, S_DONE = 5, S_ERROR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic manual_rst = 0, clear_done = 0, dl_done = 0, bit_err = 0;
  logic chk_active = 0, chk_mismatch = 0, user_hdc = 0, user_ldc = 0;
  logic usr_start_low = 0, ext_init_low = 0;
  logic [2:0] mode = 3'd0;
  logic start_pin, init_pin, start_dl, init_dl, hdc, ldc;
  logic [2:0] state;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  // wired-AND model of the open-drain lines with pull-ups
  assign start_pin = !(start_dl || usr_start_low);
  assign init_pin  = !(init_dl || ext_init_low);

  cfg_handshake_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .manual_rst_i(manual_rst), .mode_i(mode),
    .clear_done_i(clear_done), .dl_done_i(dl_done), .bit_err_i(bit_err),
    .chk_active_i(chk_active), .chk_mismatch_i(chk_mismatch),
    .start_pin_i(start_pin), .init_pin_i(init_pin),
    .user_hdc_i(user_hdc), .user_ldc_i(user_ldc),
    .start_drive_low_o(start_dl), .init_drive_low_o(init_dl),
    .hdc_o(hdc), .ldc_o(ldc), .state_o(state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_st(input string tag, input int exp);
    chk(int'(state) == exp, tag, int'(state), exp);
  endtask

  task automatic chk_phase(input string tag, input bit cfg);
    int eh, el;
    eh = cfg ? 1 : int'(user_hdc);
    el = cfg ? 0 : int'(user_ldc);
    chk(int'(hdc) == eh, {tag, " hdc"}, int'(hdc), eh);
    chk(int'(ldc) == el, {tag, " ldc"}, int'(ldc), el);
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  function automatic int exp_after_clear(input logic [2:0] m);
    return (m == 3'd0) ? S_LOAD : S_WAIT;
  endfunction

  task automatic manual_start(input int from_st);
    repeat (3) tick;
    usr_start_low = 1;
    tick; tick;
    chk_st("R5 before sync", from_st);
    tick;
    chk_st("R5 enter delay", S_DELAY);
    chk(!start_dl, "R5 not driven in delay", start_dl, 0);
    chk_phase("R9 delay", 1);
    tick; tick;
    chk_st("R5 delay length", S_DELAY);
    tick;
    chk_st("R5 delay end", S_LOAD);
    chk(start_dl, "R5 busy drive", start_dl, 1);
    usr_start_low = 0;
  endtask

  task automatic finish_ok;
    dl_done = 1;
    tick;
    dl_done = 0;
    chk_st("R6 done", S_DONE);
    chk(!start_dl, "R6 start released", start_dl, 0);
    chk_phase("R9 done", 0);
  endtask

  task automatic trial(input logic [2:0] m, input bit hold_init, input bit use_err,
                       input int clear_wait);
    mode = m;
    user_hdc = 1'($urandom);
    user_ldc = 1'($urandom);
    manual_rst = 1;
    tick;
    manual_rst = 0;
    chk_st("R1 manual reset", S_RESET);
    chk(start_dl && init_dl, "R1 reset drives", {start_dl, init_dl}, 3);
    chk_phase("R9 reset", 1);
    tick;
    chk_st("R1 reset to clear", S_CLEAR);
    repeat (clear_wait) tick;
    chk_st("R2 clear wait", S_CLEAR);
    chk(init_dl, "R2 init low in clear", init_dl, 1);
    chk_phase("R9 clear", 1);
    ext_init_low = hold_init;
    clear_done = 1;
    tick;
    clear_done = 0;
    chk(!init_dl, "R2 init released", init_dl, 0);
    if (hold_init) begin
      repeat (8) tick;
      chk_st("R2 held by external low", S_CLEAR);
      ext_init_low = 0;
    end
    tick; tick;
    chk_st("R2 sync latency", S_CLEAR);
    tick;
    chk_st(m == 0 ? "R4 auto path" : "R3 manual path", exp_after_clear(m));
    if (m != 0) begin
      chk(!start_dl, "R3 start released", start_dl, 0);
      chk_phase("R9 wait", 0);
      bit_err = 1;
      tick;
      bit_err = 0;
      chk_st("R7 error ignored in wait", S_WAIT);
      manual_start(S_WAIT);
    end else begin
      repeat (2 + ($urandom % 5)) begin
        tick;
        chk_st("R4 auto download holds", S_LOAD);
        chk(start_dl, "R4 start held low", start_dl, 1);
      end
    end
    if (use_err) begin
      bit_err = 1;
      dl_done = 1'($urandom);
      tick;
      bit_err = 0;
      dl_done = 0;
      chk_st("R7 error", S_ERROR);
      chk(init_dl && start_dl, "R7 lines low", {start_dl, init_dl}, 3);
      repeat (4) tick;
      chk_st("R7 error sticky", S_ERROR);
      chk_phase("R9 error", 1);
      return;
    end
    finish_ok();
    chk_active = 1; chk_mismatch = 1; #1;
    chk(init_dl, "R8 mismatch flagged", init_dl, 1);
    chk_mismatch = 0; #1;
    chk(!init_dl, "R8 active no mismatch", init_dl, 0);
    chk_active = 0; chk_mismatch = 1; #1;
    chk(!init_dl, "R8 mismatch not active", init_dl, 0);
    chk_mismatch = 0;
    bit_err = 1;
    tick;
    bit_err = 0;
    chk_st("R7 error ignored in done", S_DONE);
    manual_start(S_DONE);
    finish_ok();
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #10;
    chk_st("R1 async reset", S_RESET);
    chk(start_dl && init_dl, "R1 async reset drives", {start_dl, init_dl}, 3);
    chk(int'(state) <= 6, "R10 encoding", int'(state), 0);
    @(negedge clk);
    rst_n = 1;
    tick;
    chk_st("R1 after async reset", S_CLEAR);

    trial(3'd0, 0, 0, 2);
    trial(3'd2, 0, 0, 0);
    trial(3'd6, 1, 0, 3);
    trial(3'd7, 0, 0, 1);
    trial(3'd5, 0, 0, 0);
    trial(3'd0, 1, 1, 1);
    trial(3'd2, 0, 1, 0);
    for (int i = 0; i < 25; i++)
      trial(3'($urandom), 1'($urandom), ($urandom % 4) == 0, $urandom % 6);

    // async reset in the middle of a download
    trial(3'd0, 0, 0, 0);
    manual_rst = 1; tick; manual_rst = 0;
    tick;
    clear_done = 1; tick; clear_done = 0;
    repeat (3) tick;
    chk_st("R4 download before async reset", S_LOAD);
    rst_n = 0; #1;
    chk_st("R1 async reset mid download", S_RESET);
    chk_phase("R9 async reset", 1);
    @(negedge clk);
    rst_n = 1;
    tick;
    chk_st("R1 clear after async reset", S_CLEAR);

    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    end
    $finish;
  end
endmodule